// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers eight peripheral request lines into one level interrupt for the host. Peripherals set bits in a pending register through a post vector and remove them through a clear vector. Software reaches the block through a small byte-wide register port. It can write and read an enable mask, which is kept inverted, and it can retire a single request by writing its line number. It can also read the pending bits as one byte, or as a zero-extended 64-bit word.

The host interrupt is high exactly while some pending bit is also enabled. An internal flag drives it: the flag is raised on an inactive-to-active change and dropped on the reverse change. A second mask register exists so that software written for a two-controller layout still works. It stores what is written and reads it back, but it never affects the interrupt. Its status register reads as zero and its acknowledge port does nothing. The block has no priority, cascading or vectoring.

Register map (3-bit address): 0 primary mask, 1 pending, 2 acknowledge, 3 secondary mask, 4 secondary status, 5 secondary acknowledge, 6 and 7 unused. Reads are combinational from the current address and width select. Writes take effect at the clock edge that samples `reg_wr`.

Top module: `irq_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, pending is 0x00, the enable vector is 0x00 (so a read of address 0 gives 0xFF) and `irq` is low.
- R2: A write of byte W to address 0 makes the enable vector ~W. A later read of address 0 returns W.
- R3: A nonzero `post_vec` in a cycle ORs its bits into pending at that clock edge. A byte read of address 1 returns pending in bits 7:0, with bits 63:8 zero.
- R4: The bits of `clr_vec` are removed from pending at the clock edge. When a bit is posted and cleared in the same cycle, the clear wins.
- R5: A write of byte D to address 2 clears pending bit D[3:0] when D[3:0] is 0..7. An index of 8..15 has no effect, and bits 7:4 are ignored. An acknowledge wins over a post of the same bit in the same cycle.
- R6: After every clock edge, `irq` equals the OR over all lines of (pending AND enable). It changes in the same edge that changes pending or the enable vector.
- R7: A write of byte S to address 3 stores S unchanged, and a read of address 3 returns S. This register never changes `irq`, pending or the enable vector.
- R8: A read of address 4 returns 0. Writes to addresses 1, 4, 5, 6 and 7 change no state.
- R9: With `reg_wide` high, a read of address 1 returns pending zero-extended to 64 bits. A wide read of any other address returns 0.
- R10: A read of address 6 or 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data byte |
| reg_wide | input | 1 | Read width select: 1 = 64-bit read, 0 = byte read |
| reg_rdata | output | 64 | Read data; byte reads use bits 7:0 and return zero above |
| post_vec | input | 8 | Request bits to set in pending |
| clr_vec | input | 8 | Request bits to remove from pending |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions take the post and clear vectors, the write strobe and the address to be clean, known values at every sampling edge. They also assume that nothing but the register port, post and clear can change state. The bench drives all inputs on the falling edge and returns them to zero afterwards, so each stimulus is active for exactly one rising edge. It only reads the combinational read port while no write is being driven. The sweeps cover every primary-mask byte, every secondary-mask byte, all sixteen acknowledge indices and mixed post/clear patterns. Expected values come from a byte-level model in the bench.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int unsigned LINES_DEF = 8;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned WIDE_W    = 64;

  typedef enum logic [ADDR_W-1:0] {
    RA_EN_MASK  = 3'd0,
    RA_PENDING  = 3'd1,
    RA_ACK      = 3'd2,
    RA_SEC_MASK = 3'd3,
    RA_SEC_STAT = 3'd4,
    RA_SEC_ACK  = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic en_wr;
    logic ack_wr;
    logic sec_wr;
  } wr_stb_t;

  typedef struct packed {
    logic en;
    logic pend;
    logic sec;
  } rd_sel_t;
endpackage

// File: rtl/irq_decode.sv
`timescale 1ns/1ps
module irq_decode
  import irq_ctrl_pkg::*;
(
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output wr_stb_t           wstb,
  output rd_sel_t           rsel
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e r);
    return a == r;
  endfunction

  always_comb begin
    wstb.en_wr  = reg_wr && hit(reg_addr, RA_EN_MASK);
    wstb.ack_wr = reg_wr && hit(reg_addr, RA_ACK);
    wstb.sec_wr = reg_wr && hit(reg_addr, RA_SEC_MASK);
    rsel.en     = hit(reg_addr, RA_EN_MASK);
    rsel.pend   = hit(reg_addr, RA_PENDING);
    rsel.sec    = hit(reg_addr, RA_SEC_MASK);
  end
endmodule

// File: rtl/irq_pending.sv
`timescale 1ns/1ps
module irq_pending
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NLINES = LINES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] post_vec,
  input  logic [NLINES-1:0] clr_vec,
  input  logic              ack_wr,
  input  logic [IDX_W-1:0]  ack_idx,
  output logic [NLINES-1:0] pend_q,
  output logic [NLINES-1:0] pend_nxt
);
  logic [NLINES-1:0] ack_vec;

  function automatic logic [NLINES-1:0] ack_decode(input logic en, input logic [IDX_W-1:0] idx);
    logic [NLINES-1:0] v;
    v = '0;
    for (int i = 0; i < NLINES; i++)
      if (en && (idx == IDX_W'(i))) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic bit_next(input logic cur, input logic set, input logic rm);
    return (cur | set) & ~rm;
  endfunction

  assign ack_vec = ack_decode(ack_wr, ack_idx);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign pend_nxt[g] = bit_next(pend_q[g], post_vec[g], clr_vec[g] | ack_vec[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_nxt[g];
    end
  end

  // R3: posted bits not removed in the same cycle are present afterwards
  assert_post_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|post_vec) |=> ((pend_q & ($past(post_vec) & ~$past(clr_vec) & ~$past(ack_vec)))
                     == ($past(post_vec) & ~$past(clr_vec) & ~$past(ack_vec))));

  // R4: cleared bits are gone after the edge, whatever was posted
  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((pend_q & $past(clr_vec)) == '0));

  // R5: an acknowledged line is not pending after the edge
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (ack_idx < IDX_W'(NLINES))) |=> (pend_q[$past(ack_idx)] == 1'b0));

  // R5: an out-of-range index leaves pending untouched when nothing else moves
  assert_ack_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (ack_idx >= IDX_W'(NLINES)) && post_vec == '0 && clr_vec == '0)
      |=> $stable(pend_q));
endmodule

// File: rtl/irq_enable.sv
`timescale 1ns/1ps
module irq_enable
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NLINES = LINES_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              sec_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NLINES-1:0] pend_q,
  input  logic [NLINES-1:0] pend_nxt,
  output logic [NLINES-1:0] en_q,
  output logic [DATA_W-1:0] sec_q,
  output logic              irq_q
);
  logic [NLINES-1:0] en_nxt;
  logic              active_nxt;
  logic              raise_evt;
  logic              drop_evt;

  function automatic logic any_live(input logic [NLINES-1:0] p, input logic [NLINES-1:0] e);
    return |(p & e);
  endfunction

  assign en_nxt     = en_wr ? ~wdata[NLINES-1:0] : en_q;
  assign active_nxt = any_live(pend_nxt, en_nxt);
  assign raise_evt  = !irq_q && active_nxt;
  assign drop_evt   = irq_q && !active_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q <= en_nxt;
      if (sec_wr) sec_q <= wdata;
      if (raise_evt)     irq_q <= 1'b1;
      else if (drop_evt) irq_q <= 1'b0;
    end
  end

  // R6: the flag agrees with the stored pending and enable state
  assert_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|(pend_q & en_q)));

  // R6: a raise event is visible on the next cycle
  assert_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> irq_q);

  // R2: enable holds the complement of the written byte
  assert_mask_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == ~$past(wdata[NLINES-1:0])));

  // R7: a secondary mask write alone leaves the enable vector unchanged
  assert_sec_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wr && !en_wr) |=> $stable(en_q));

  // R7: with pending and enable unchanged the output does not move
  assert_no_side_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pend_q) && $stable(en_q)) |-> $stable(irq_q));
endmodule

// File: rtl/irq_rdmux.sv
`timescale 1ns/1ps
module irq_rdmux
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NLINES = LINES_DEF,
  parameter int unsigned RD_W   = WIDE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_sel_t           rsel,
  input  logic              wide,
  input  logic [NLINES-1:0] en_q,
  input  logic [NLINES-1:0] pend_q,
  input  logic [DATA_W-1:0] sec_q,
  output logic [RD_W-1:0]   rdata
);
  localparam int unsigned PAD_B = DATA_W - NLINES;

  function automatic logic [DATA_W-1:0] byte_view(input rd_sel_t s,
                                                  input logic [NLINES-1:0] e,
                                                  input logic [NLINES-1:0] p,
                                                  input logic [DATA_W-1:0] sm);
    logic [DATA_W-1:0] b;
    b = '0;
    if (s.en)   b = {{PAD_B{1'b1}}, ~e};
    if (s.pend) b = DATA_W'(p);
    if (s.sec)  b = sm;
    return b;
  endfunction

  always_comb begin
    if (wide) rdata = rsel.pend ? RD_W'(pend_q) : '0;
    else      rdata = RD_W'(byte_view(rsel, en_q, pend_q, sec_q));
  end

  // R9: a wide read never shows bits above the request lines
  assert_wide_zext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> (rdata[RD_W-1:NLINES] == '0));

  // R3: byte reads never show bits above the byte
  assert_byte_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (rdata[RD_W-1:DATA_W] == '0));
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NLINES = LINES_DEF,
  parameter int unsigned RD_W   = WIDE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wide,
  output logic [RD_W-1:0]   reg_rdata,
  input  logic [NLINES-1:0] post_vec,
  input  logic [NLINES-1:0] clr_vec,
  output logic              irq
);
  wr_stb_t           wstb;
  rd_sel_t           rsel;
  logic [NLINES-1:0] pend_q;
  logic [NLINES-1:0] pend_nxt;
  logic [NLINES-1:0] en_q;
  logic [DATA_W-1:0] sec_q;

  irq_decode u_dec (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wstb     (wstb),
    .rsel     (rsel)
  );

  irq_pending #(.NLINES(NLINES)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .post_vec (post_vec),
    .clr_vec  (clr_vec),
    .ack_wr   (wstb.ack_wr),
    .ack_idx  (reg_wdata[IDX_W-1:0]),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt)
  );

  irq_enable #(.NLINES(NLINES)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (wstb.en_wr),
    .sec_wr   (wstb.sec_wr),
    .wdata    (reg_wdata),
    .pend_q   (pend_q),
    .pend_nxt (pend_nxt),
    .en_q     (en_q),
    .sec_q    (sec_q),
    .irq_q    (irq)
  );

  irq_rdmux #(.NLINES(NLINES), .RD_W(RD_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rsel   (rsel),
    .wide   (reg_wide),
    .en_q   (en_q),
    .pend_q (pend_q),
    .sec_q  (sec_q),
    .rdata  (reg_rdata)
  );

  // R1: nothing is signalled in the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  // R8: writes to the read-only and unused addresses move no state
  assert_dead_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wstb.en_wr && !wstb.ack_wr && !wstb.sec_wr && post_vec == '0 && clr_vec == '0)
      |=> ($stable(pend_q) && $stable(en_q) && $stable(sec_q)));
endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic        reg_wide;
  logic [63:0] reg_rdata;
  logic [7:0]  post_vec;
  logic [7:0]  clr_vec;
  logic        irq;

  always #10 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wide(reg_wide), .reg_rdata(reg_rdata),
    .post_vec(post_vec), .clr_vec(clr_vec), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] m_pend, m_en, m_sec;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic w, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a; reg_wide = w;
    #2 v = reg_rdata;
    reg_wide = 1'b0;
  endtask

  task automatic drive(input logic [7:0] p, input logic [7:0] c);
    @(negedge clk);
    post_vec = p; clr_vec = c;
    @(negedge clk);
    post_vec = '0; clr_vec = '0;
  endtask

  function automatic logic exp_irq();
    return |(m_pend & m_en);
  endfunction

  task automatic chk_state(input string req);
    logic [63:0] v;
    chk({63'b0, irq}, {63'b0, exp_irq()}, req);
    rd(3'd1, 1'b0, v);
    chk(v, {56'b0, m_pend}, req);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; reg_wide = 0;
    post_vec = 0; clr_vec = 0;
    m_pend = 0; m_en = 0; m_sec = 0;
    repeat (3) @(negedge clk);
    chk({63'b0, irq}, 64'd0, "R1 irq in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk({63'b0, irq}, 64'd0, "R1 irq after reset");
    rd(3'd0, 1'b0, v); chk(v, 64'hFF, "R1 mask read");
    rd(3'd1, 1'b0, v); chk(v, 64'h0, "R1 pending read");
    rd(3'd1, 1'b1, v); chk(v, 64'h0, "R1 wide pending read");

    // R2 sweep of every mask byte
    for (int m = 0; m < 256; m++) begin
      wr(3'd0, 8'(m)); m_en = ~8'(m);
      rd(3'd0, 1'b0, v); chk(v, 64'(m), "R2 mask readback");
    end
    chk({63'b0, irq}, 64'd0, "R6 idle irq");

    // R3 R4 R6 mixed post/clear patterns against varied masks
    for (int i = 0; i < 64; i++) begin
      logic [7:0] w, p, q, c;
      w = 8'((i * 91 + 5) & 255);
      p = 8'((i * 37 + 11) & 255);
      q = 8'((i * 29 + 7) & 255);
      c = 8'((i * 53 + 3) & 255);
      wr(3'd0, w); m_en = ~w;
      chk({63'b0, irq}, {63'b0, exp_irq()}, "R6 after mask write");
      drive(p, 8'h00); m_pend = m_pend | p;
      chk_state("R3 post");
      drive(q, c); m_pend = (m_pend | q) & ~c;
      chk_state("R4 post and clear");
      rd(3'd1, 1'b1, v); chk(v, {56'b0, m_pend}, "R9 wide pending");
    end

    // R5 acknowledge sweep over all sixteen indices
    wr(3'd0, 8'h00); m_en = 8'hFF;
    for (int k = 0; k < 16; k++) begin
      drive(8'hFF, 8'h00); m_pend = 8'hFF;
      wr(3'd2, 8'(((k * 5) & 15) << 4) | 8'(k));
      if (k < 8) m_pend[k] = 1'b0;
      chk_state("R5 ack index");
    end
    // R5 ack beats post of the same bit
    drive(8'h00, 8'hFF); m_pend = 0;
    @(negedge clk);
    post_vec = 8'h30; reg_addr = 3'd2; reg_wdata = 8'h05; reg_wr = 1'b1;
    @(negedge clk);
    post_vec = 0; reg_wr = 0; m_pend = 8'h10;
    chk_state("R5 ack over post");
    // R4 clear of a single bit drops irq
    wr(3'd0, 8'hEF); m_en = 8'h10;
    chk({63'b0, irq}, 64'd1, "R6 single enabled line");
    drive(8'h00, 8'h10); m_pend = 0;
    chk_state("R4 clear drops irq");

    // R7 secondary mask sweep, irq low then high
    wr(3'd0, 8'h00); m_en = 8'hFF;
    for (int s = 0; s < 256; s++) begin
      wr(3'd3, 8'(s)); m_sec = 8'(s);
      rd(3'd3, 1'b0, v); chk(v, 64'(s), "R7 secondary readback");
      chk({63'b0, irq}, 64'd0, "R7 secondary no irq");
    end
    drive(8'h04, 8'h00); m_pend = 8'h04;
    wr(3'd3, 8'h00);
    chk({63'b0, irq}, 64'd1, "R7 secondary cannot mask");
    rd(3'd0, 1'b0, v); chk(v, 64'h00, "R7 primary unchanged");

    // R8 R9 R10 dead reads and writes
    rd(3'd4, 1'b0, v); chk(v, 64'h0, "R8 secondary status");
    wr(3'd5, 8'hFF); wr(3'd4, 8'hFF); wr(3'd1, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    chk_state("R8 ignored writes");
    rd(3'd0, 1'b0, v); chk(v, 64'h00, "R8 mask kept");
    rd(3'd3, 1'b0, v); chk(v, 64'h00, "R8 secondary kept");
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), 1'b1, v);
      chk(v, (a == 1) ? {56'b0, m_pend} : 64'h0, "R9 wide read by address");
    end
    rd(3'd6, 1'b0, v); chk(v, 64'h0, "R10 address 6");
    rd(3'd7, 1'b0, v); chk(v, 64'h0, "R10 address 7");

    // R1 reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_pend = 0; m_en = 0;
    chk_state("R1 re-reset");
    rd(3'd0, 1'b0, v); chk(v, 64'hFF, "R1 mask after re-reset");

    summary();
    $finish;
  end
endmodule